// File: doc/BRIEF.md
# SPI Master Clock Generator and Transmitter

The block generates the serial clock of an SPI master and shifts out transmit words on MOSI. Two stages produce the clock. The first is a fixed divide-by-eight prescaler, which can be bypassed. The second is an 8-bit modulus counter that divides by the programmed value plus one. Each SCK half-period therefore lasts prescale × (modulus + 1) system clocks. The result is shaped by the programmed clock polarity and clock phase.

The host writes a 24-bit word into a holding register. Whenever the shift register is free, the holding register hands its word to the shift register, and the empty flag rises again in the same clock. The word is sent most significant bit first, over 48 SCK edges. When no word is pending, SCK rests at its idle level.

A configuration word is written through a strobe and can be read back at all times. In slave mode the divider settings are ignored, no clock is produced and no word is sent. A synchronous software reset returns the configuration and the transmit path to their reset state.

Top module: `spim_sckgen_tx`

## Requirements
- R1: After asynchronous reset, cfg_o reads 16'h0400, tx_empty_o is 1, and sck_o and mosi_o are 0.
- R2: A clock edge with soft_rst_i high has the same effect as R1. It aborts any transfer, and cfg_o reads 16'h0400 afterwards.
- R3: The configuration layout is: modulus in bits [7:0], prescaler bypass in bit 8, polarity in bit 9, phase in bit 10 and the filter mode in bits [12:11]. All five fields are stored on cfg_we_i and read back on cfg_o. Bits [15:13] always read 0.
- R4: Every SCK half-period lasts P×(M+1) system clocks. P is 8 when bypass is 0 and 1 when bypass is 1, and M is the modulus field (0 to 255). The first SCK edge comes P×(M+1) clocks after the word is loaded.
- R5: SCK rests at the polarity bit whenever no transfer is running (0 idles low, 1 idles high).
- R6: With phase 0, MOSI presents bit 23 at load and changes on each trailing edge. With phase 1, MOSI changes on each leading edge.
- R7: A word is 24 bits, sent MSB first over 48 SCK edges. After the last edge SCK returns to idle and the transfer ends.
- R8: A host write sets tx_empty_o to 0 on the next cycle. A write while the flag is 0 replaces the pending word.
- R9: The pending word moves into the shift register on the first clock when no transfer runs. tx_empty_o returns to 1 on that same clock.
- R10: With master_i low, SCK stays at its idle level, the pending word is not sent, and tx_empty_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous software reset |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_o | output | 16 | Configuration readback |
| tx_we_i | input | 1 | Holding register write strobe |
| tx_data_i | input | 24 | Holding register write data |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| tx_empty_o | output | 1 | Holding register empty flag |

## Verification
Words with distinct bit patterns are sent under each phase and polarity combination, so that a wrong bit order or a wrong data-change edge shows up on MOSI. The divider is run with the prescaler active and a small modulus, with the bypass set and modulus 0, and with the bypass set and modulus 255. Together these separate the prescaler, the plus-one term and the full 8-bit range. A second write during a running transfer shows that an overwrite leaves only the newest word pending. Slave mode and a software reset in mid-transfer confirm that the clock and the data stop where they should.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int CFG_W   = 16;
  localparam int MOD_W   = 8;
  localparam int PRE_W   = 3;
  localparam int WORD_W  = 24;

  typedef struct packed {
    logic [1:0]       filt;
    logic             cpha;
    logic             cpol;
    logic             bypass;
    logic [MOD_W-1:0] modulus;
  } cfg_t;

  localparam int CFG_USED = $bits(cfg_t);

  localparam cfg_t CFG_RST = '{filt: 2'b00, cpha: 1'b1, cpol: 1'b0,
                               bypass: 1'b0, modulus: '0};
endpackage

// File: rtl/spim_cfg_regs.sv
module spim_cfg_regs
  import spim_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [CFG_W-1:0] rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= CFG_RST;
    else if (soft_rst_i) cfg_q <= CFG_RST;
    else if (we_i)       cfg_q <= cfg_t'(wdata_i[CFG_USED-1:0]);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(CFG_W-CFG_USED){1'b0}}, cfg_q};

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[CFG_W-1:CFG_USED] == '0); // R3
endmodule

// File: rtl/spim_clk_div.sv
module spim_clk_div #(
  parameter int  MOD_W   = 8,
  parameter int  PRE_W   = 3,
  parameter bit  HAS_PRE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bypass_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             tick_o
);
  logic             pre_done;
  logic [MOD_W-1:0] mod_q;

  generate
    if (HAS_PRE) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      assign pre_done = bypass_i | (pre_q == '1);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 pre_q <= '0;
        else if (clr_i || !en_i)     pre_q <= '0;
        else if (bypass_i)           pre_q <= '0;
        else                         pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign pre_done = 1'b1;
    end
  endgenerate

  assign tick_o = en_i & pre_done & (mod_q == mod_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             mod_q <= '0;
    else if (clr_i || !en_i) mod_q <= '0;
    else if (pre_done)       mod_q <= (mod_q == mod_i) ? '0 : mod_q + 1'b1;
  end

  AST_MOD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i |-> mod_q <= mod_i); // R4
endmodule

// File: rtl/spim_tx_shift.sv
module spim_tx_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              master_i,
  input  logic              cpha_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              ph_o,
  output logic              mosi_o,
  output logic              empty_o
);
  localparam int EDGES = 2 * WORD_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic [WORD_W-1:0] hold_q, sh_q;
  logic              empty_q, busy_q, ph_q, mosi_q;
  logic [EW-1:0]     edge_q;
  logic              load, lead, drive;

  assign load  = master_i & ~busy_q & ~empty_q;
  assign lead  = ~edge_q[0];
  assign drive = lead ? cpha_i : (~cpha_i & (edge_q != LAST_EDGE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0; sh_q <= '0; empty_q <= 1'b1; busy_q <= 1'b0;
      ph_q <= 1'b0; mosi_q <= 1'b0; edge_q <= '0;
    end else if (soft_rst_i) begin
      hold_q <= '0; sh_q <= '0; empty_q <= 1'b1; busy_q <= 1'b0;
      ph_q <= 1'b0; mosi_q <= 1'b0; edge_q <= '0;
    end else begin
      if (!master_i) begin
        busy_q <= 1'b0;
        ph_q   <= 1'b0;
        edge_q <= '0;
      end else if (busy_q) begin
        if (tick_i) begin
          ph_q <= ~ph_q;
          if (drive) begin
            mosi_q <= sh_q[WORD_W-1];
            sh_q   <= sh_q << 1;
          end
          if (edge_q == LAST_EDGE) begin
            busy_q <= 1'b0;
            edge_q <= '0;
          end else begin
            edge_q <= edge_q + 1'b1;
          end
        end
      end else if (load) begin
        busy_q  <= 1'b1;
        edge_q  <= '0;
        empty_q <= 1'b1;
        if (cpha_i) begin
          sh_q <= hold_q;
        end else begin
          mosi_q <= hold_q[WORD_W-1];
          sh_q   <= hold_q << 1;
        end
      end
      // a host write in the load cycle wins the holding register
      if (we_i) begin
        hold_q  <= data_i;
        empty_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign ph_o    = ph_q;
  assign mosi_o  = mosi_q;
  assign empty_o = empty_q;

  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !soft_rst_i |=> !empty_o); // R8
  AST_LOAD_SETS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && !we_i && !soft_rst_i |=> empty_o && busy_o); // R9
  AST_IDLE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !ph_q); // R5
  AST_TOGGLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && master_i && !tick_i && !soft_rst_i |=> $stable(ph_q)); // R4
endmodule

// File: rtl/spim_sckgen_tx.sv
module spim_sckgen_tx
  import spim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              master_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_o,
  input  logic              tx_we_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              tx_empty_o
);
  cfg_t cfg;
  logic busy, ph, tick;

  spim_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .cfg_o      (cfg),
    .rdata_o    (cfg_o)
  );

  spim_clk_div #(.MOD_W(MOD_W), .PRE_W(PRE_W), .HAS_PRE(1'b1)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst_i),
    .en_i     (busy & master_i),
    .bypass_i (cfg.bypass),
    .mod_i    (cfg.modulus),
    .tick_o   (tick)
  );

  spim_tx_shift #(.WORD_W(WORD_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .master_i   (master_i),
    .cpha_i     (cfg.cpha),
    .we_i       (tx_we_i),
    .data_i     (tx_data_i),
    .tick_i     (tick),
    .busy_o     (busy),
    .ph_o       (ph),
    .mosi_o     (mosi_o),
    .empty_o    (tx_empty_o)
  );

  assign sck_o = cfg.cpol ^ ph;

  AST_SOFT_RST_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> cfg_o == CFG_W'(CFG_RST) && tx_empty_o); // R2
  AST_SLAVE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> sck_o == cfg_o[9]); // R10
endmodule

// File: tb/tb_spim_sckgen_tx.sv
module tb_spim_sckgen_tx;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 190000;

  logic        clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, master = 1'b1;
  logic        cfg_we = 1'b0, tx_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [23:0] tx_data = '0;
  logic [15:0] cfg_rd;
  logic        sck, mosi, empty;

  int    n_tests = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [12:0] m_cfg;
  logic [23:0] m_hold, m_sh;
  logic        m_empty, m_busy, m_ph, m_mosi;
  int          m_cnt, m_edge;

  always #(CLK_PERIOD/2) clk = ~clk;

  spim_sckgen_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .master_i(master),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_o(cfg_rd),
    .tx_we_i(tx_we), .tx_data_i(tx_data),
    .sck_o(sck), .mosi_o(mosi), .tx_empty_o(empty)
  );

  function automatic int half_period();
    return (m_cfg[8] ? 1 : 8) * (int'(m_cfg[7:0]) + 1);
  endfunction

  task automatic model_clear();
    m_cfg = 13'h0400; m_hold = '0; m_sh = '0; m_empty = 1'b1; m_busy = 1'b0;
    m_ph = 1'b0; m_mosi = 1'b0; m_cnt = 0; m_edge = 0;
  endtask

  initial model_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) model_clear();
    else begin
      if (!master) begin
        m_busy = 1'b0; m_ph = 1'b0; m_edge = 0; m_cnt = 0;
      end else if (m_busy) begin
        if (m_cnt == half_period() - 1) begin
          m_cnt = 0;
          m_ph  = ~m_ph;
          if ((m_edge % 2 == 0) ? m_cfg[10] : (!m_cfg[10] && m_edge != 47)) begin
            m_mosi = m_sh[23]; m_sh = m_sh << 1;
          end
          if (m_edge == 47) begin m_busy = 1'b0; m_edge = 0; end
          else m_edge++;
        end else m_cnt++;
      end else if (!m_empty) begin
        m_busy = 1'b1; m_cnt = 0; m_edge = 0; m_empty = 1'b1;
        if (m_cfg[10]) m_sh = m_hold;
        else begin m_mosi = m_hold[23]; m_sh = m_hold << 1; end
      end
      if (tx_we) begin m_hold = tx_data; m_empty = 1'b0; end
      if (cfg_we) m_cfg = cfg_wdata[12:0];
    end
  end

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (sck !== (m_cfg[9] ^ m_ph) || mosi !== m_mosi || empty !== m_empty ||
          cfg_rd !== {3'b000, m_cfg}) begin
        n_fail++;
        $display("FAIL %s: sck/mosi/empty/cfg act %b/%b/%b/%h exp %b/%b/%b/%h",
                 cur_req, sck, mosi, empty, cfg_rd,
                 m_cfg[9] ^ m_ph, m_mosi, m_empty, {3'b000, m_cfg});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: act %0d cycles exp <= %0d", cycles, LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic host_write(input logic [23:0] d);
    @(negedge clk); tx_we = 1'b1; tx_data = d;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!m_busy && m_empty) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // measure the first SCK edge after a write to an idle block (R4)
  task automatic send_timed(input logic [23:0] d, input int hp);
    int n;
    logic idle;
    idle = sck;
    host_write(d);
    check(empty == 1'b0, "R8 empty after write", empty, 0);
    n = 0;
    while (sck == idle && n < 5000) begin
      @(negedge clk); n++;
      if (n == 1) check(empty == 1'b1, "R9 empty at handoff", empty, 1);
    end
    check(n == hp + 1, "R4 first edge delay", n, hp + 1);
    wait_idle();
    check(sck == idle, "R7 idle after word", sck, idle);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check(cfg_rd == 16'h0400, "R1 cfg", cfg_rd, 16'h0400);
    check(empty == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R1 outputs",
          {empty, sck, mosi}, 3'b100);

    cur_req = "R3";
    cfg_write(16'hFFFF);
    check(cfg_rd == 16'h1FFF, "R3 reserved zero", cfg_rd, 16'h1FFF);
    cfg_write(16'h1805);
    check(cfg_rd == 16'h1805, "R3 filter kept", cfg_rd, 16'h1805);

    // phase 1, polarity 0, prescaler on, modulus 2
    cur_req = "R6";
    cfg_write(16'h0402);
    send_timed(24'hA5C3F0, 24);

    // phase 0, polarity 1, bypass, modulus 0
    cur_req = "R5";
    cfg_write(16'h0300);
    check(sck == 1'b1, "R5 idle high", sck, 1);
    send_timed(24'h813C7E, 1);

    // overwrite while pending, back-to-back handoff
    cur_req = "R8";
    cfg_write(16'h0503);
    host_write(24'h123456);
    host_write(24'hFEDCBA);
    host_write(24'h0F0F0F);
    check(empty == 1'b0, "R8 pending", empty, 0);
    wait_idle();

    // bypass with full modulus
    cur_req = "R4";
    cfg_write(16'h01FF);
    send_timed(24'hC00001, 256);

    // slave mode: nothing moves
    cur_req = "R10";
    cfg_write(16'h0401);
    @(negedge clk); master = 1'b0;
    host_write(24'h5A5A5A);
    repeat (300) @(negedge clk);
    check(sck == 1'b0 && empty == 1'b0, "R10 held", {sck, empty}, 2'b00);
    master = 1'b1;
    wait_idle();

    // soft reset mid-transfer
    cur_req = "R2";
    cfg_write(16'h0305);
    host_write(24'hFFFFFF);
    repeat (40) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check(cfg_rd == 16'h0400, "R2 cfg", cfg_rd, 16'h0400);
    check(empty == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R2 outputs",
          {empty, sck, mosi}, 3'b100);
    repeat (100) @(negedge clk);
    check(sck == 1'b0, "R7 stays idle", sck, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule